// File: doc/BRIEF.md
# Triggered Test-Pattern Event Transmitter

This block replays stored test events onto a valid/ready output link. The host first loads a flat pattern memory and a small table of event descriptors. A trigger strobe then starts each event. The strobe carries a 2-bit buffer number, and that number is stamped on every word of the event it starts.

Each descriptor sets four things for its event:
- the start address in pattern memory;
- the word count, where zero means an empty event;
- the number of idle cycles placed between words;
- a pre-send delay, long enough to span about half a second at a 40 MHz clock.

Triggers that arrive while an event is still in progress wait in a short queue. A sticky flag reports a trigger that was lost because the queue was full.

A mode input controls which descriptor each trigger uses. In one setting, every trigger replays the current descriptor. In the other, the descriptor pointer steps forward after each event and returns to entry 0 after a programmable last entry. Words leave through a small output FIFO. The final word of each event carries an end-of-event flag. An empty event produces a single end-of-event beat with zero data.

Top module: `tpx_top`

## Requirements
- R1: After reset, `tx_valid` is 0, `ovf_err` is 0 and the descriptor pointer is entry 0.
- R2: No word is emitted unless a trigger (`l1a` high for one cycle) has been received.
- R3: An event with N>0 words emits the pattern words at start, start+1, … in order. Only the last word has `tx_eoe`=1, and every word carries the `tx_buf` value captured with its trigger.
- R4: When the block is idle, the first word of an event becomes valid exactly D+4 clock edges after the edge that samples the trigger, where D is the descriptor delay.
- R5: With `tx_ready` held high, consecutive words of an event are G+1 cycles apart, where G is the descriptor gap count.
- R6: A descriptor with word count 0 emits exactly one beat, with `tx_eoe`=1 and `tx_data`=0.
- R7: With `step_mode`=0 every trigger replays the current descriptor. With `step_mode`=1 the pointer advances after each event and wraps from `last_entry` to entry 0.
- R8: Up to 4 triggers that arrive while an event is busy are queued and served in arrival order. A trigger that arrives while the queue holds 4 is dropped and sets `ovf_err`, which stays set until reset.
- R9: While `tx_valid`=1 and `tx_ready`=0, `tx_data`, `tx_eoe` and `tx_buf` stay unchanged, and no word is lost or duplicated.
- R10: The pattern memory is one flat space. Read addresses wrap modulo the memory depth, so an event that starts at depth-2 with 4 words reads depth-2, depth-1, 0, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_addr | input | AW | Pattern memory write address |
| pat_wdata | input | DW | Pattern memory write data |
| desc_we | input | 1 | Descriptor write strobe |
| desc_idx | input | DIW | Descriptor entry to write |
| desc_start | input | AW | Event start address |
| desc_words | input | AW+1 | Event word count (0 = empty event) |
| desc_gap | input | GAP_W | Idle cycles between words |
| desc_delay | input | DLY_W | Cycles of delay before the first word |
| step_mode | input | 1 | 0 = replay the same descriptor, 1 = step through the table |
| last_entry | input | DIW | Last descriptor index before the pointer wraps |
| l1a | input | 1 | Trigger strobe |
| l1a_buf | input | BUF_W | Buffer number sent with the trigger |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Downstream ready |
| tx_data | output | DW | Output word |
| tx_eoe | output | 1 | End-of-event marker |
| tx_buf | output | BUF_W | Buffer number of the event |
| ovf_err | output | 1 | Sticky trigger queue overflow |

## Verification
The hardest state to reach is a full trigger queue with a fifth trigger arriving. This needs an event that stays busy long enough for four more triggers to be waiting and not yet popped. The stimulus uses a descriptor with a 60-cycle delay. It fires one trigger, which is taken at once, then four more that fill the queue. The flag is checked while still clear before the sixth trigger and checked set after it. All five accepted events must then drain in order, each with its own buffer number. A second hard case is the output FIFO under backpressure. Holding `tx_ready` low while an event is already under way fills the FIFO through the read pipeline. The output must then stay stable and lose nothing.

// File: rtl/tpx_pkg.sv
package tpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND,
    ST_MARK
  } tx_state_t;
endpackage

// File: rtl/tpx_fifo.sv
module tpx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && (cnt != LW'(DEPTH));

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end

  assign dout  = mem[rp];
  assign level = cnt;
endmodule

// File: rtl/tpx_patmem.sv
module tpx_patmem #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tpx_seq.sv
module tpx_seq
  import tpx_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DESC_N    = 8,
  parameter int GAP_W     = 8,
  parameter int DLY_W     = 25,
  parameter int BUF_W     = 2,
  parameter int OUT_DEPTH = 4,
  localparam int CW  = AW + 1,
  localparam int DIW = $clog2(DESC_N),
  localparam int OLW = $clog2(OUT_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             desc_we,
  input  logic [DIW-1:0]   desc_idx,
  input  logic [AW-1:0]    desc_start,
  input  logic [CW-1:0]    desc_words,
  input  logic [GAP_W-1:0] desc_gap,
  input  logic [DLY_W-1:0] desc_delay,
  input  logic             step_mode,
  input  logic [DIW-1:0]   last_entry,
  input  logic             q_empty,
  input  logic [BUF_W-1:0] q_buf,
  output logic             q_pop,
  input  logic [OLW-1:0]   out_level,
  output logic             mem_re,
  output logic [AW-1:0]    mem_raddr,
  output logic             pend_v,
  output logic             pend_eoe,
  output logic             pend_zero,
  output logic [BUF_W-1:0] pend_buf
);
  typedef struct packed {
    logic [AW-1:0]    start;
    logic [CW-1:0]    words;
    logic [GAP_W-1:0] gap;
    logic [DLY_W-1:0] delay;
  } desc_t;

  desc_t            table_q [DESC_N];
  desc_t            cur;
  tx_state_t        state;
  logic [DIW-1:0]   ptr, nxt_ptr;
  logic [AW-1:0]    addr;
  logic [CW-1:0]    remain;
  logic [GAP_W-1:0] gapcnt, cur_gap;
  logic [DLY_W-1:0] dcnt;
  logic [BUF_W-1:0] cur_buf;
  logic             has_room, issue, mark;

  always_ff @(posedge clk) begin
    if (desc_we) table_q[desc_idx] <= '{desc_start, desc_words, desc_gap, desc_delay};
  end

  assign cur      = table_q[ptr];
  assign has_room = (int'(out_level) + int'(pend_v)) < OUT_DEPTH;
  assign issue    = (state == ST_SEND) && (gapcnt == '0) && has_room;
  assign mark     = (state == ST_MARK) && has_room;
  assign q_pop    = (state == ST_IDLE) && !q_empty;
  assign mem_re    = issue;
  assign mem_raddr = addr;
  assign nxt_ptr  = !step_mode ? ptr :
                    (ptr == last_entry) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      addr      <= '0;
      remain    <= '0;
      gapcnt    <= '0;
      cur_gap   <= '0;
      dcnt      <= '0;
      cur_buf   <= '0;
      pend_v    <= 1'b0;
      pend_eoe  <= 1'b0;
      pend_zero <= 1'b0;
      pend_buf  <= '0;
    end else begin
      pend_v    <= issue || mark;
      pend_eoe  <= mark || (issue && remain == CW'(1));
      pend_zero <= mark;
      pend_buf  <= cur_buf;
      unique case (state)
        ST_IDLE: if (!q_empty) begin
          cur_buf <= q_buf;
          addr    <= cur.start;
          remain  <= cur.words;
          cur_gap <= cur.gap;
          dcnt    <= cur.delay;
          gapcnt  <= '0;
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (dcnt == '0) state <= (remain == '0) ? ST_MARK : ST_SEND;
          else            dcnt  <= dcnt - 1'b1;
        end
        ST_SEND: begin
          if (gapcnt != '0) gapcnt <= gapcnt - 1'b1;
          else if (has_room) begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
            gapcnt <= cur_gap;
            if (remain == CW'(1)) begin
              state <= ST_IDLE;
              ptr   <= nxt_ptr;
            end
          end
        end
        ST_MARK: if (has_room) begin
          state <= ST_IDLE;
          ptr   <= nxt_ptr;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  issue_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> (remain != '0));

  // R5
  gap_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && cur_gap != '0 && remain != CW'(1)) |=> !issue);
endmodule

// File: rtl/tpx_top.sv
module tpx_top #(
  parameter int DW        = 32,
  parameter int PAT_DEPTH = 1024,
  parameter int DESC_N    = 8,
  parameter int GAP_W     = 8,
  parameter int DLY_W     = 25,
  parameter int BUF_W     = 2,
  parameter int Q_DEPTH   = 4,
  parameter int OUT_DEPTH = 4,
  localparam int AW  = $clog2(PAT_DEPTH),
  localparam int DIW = $clog2(DESC_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pat_we,
  input  logic [AW-1:0]    pat_addr,
  input  logic [DW-1:0]    pat_wdata,
  input  logic             desc_we,
  input  logic [DIW-1:0]   desc_idx,
  input  logic [AW-1:0]    desc_start,
  input  logic [AW:0]      desc_words,
  input  logic [GAP_W-1:0] desc_gap,
  input  logic [DLY_W-1:0] desc_delay,
  input  logic             step_mode,
  input  logic [DIW-1:0]   last_entry,
  input  logic             l1a,
  input  logic [BUF_W-1:0] l1a_buf,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [DW-1:0]    tx_data,
  output logic             tx_eoe,
  output logic [BUF_W-1:0] tx_buf,
  output logic             ovf_err
);
  localparam int QLW = $clog2(Q_DEPTH + 1);
  localparam int OLW = $clog2(OUT_DEPTH + 1);
  localparam int OW  = DW + 1 + BUF_W;

  logic [QLW-1:0]   q_level;
  logic [BUF_W-1:0] q_buf;
  logic             q_pop, q_empty, q_full;
  logic [OLW-1:0]   o_level;
  logic [OW-1:0]    o_din, o_dout;
  logic             mem_re;
  logic [AW-1:0]    mem_raddr;
  logic [DW-1:0]    mem_rdata;
  logic             pend_v, pend_eoe, pend_zero;
  logic [BUF_W-1:0] pend_buf;

  assign q_empty = (q_level == '0);
  assign q_full  = (q_level == QLW'(Q_DEPTH));

  tpx_fifo #(.W(BUF_W), .DEPTH(Q_DEPTH)) u_trig_q (
    .clk(clk), .rst(rst), .push(l1a), .din(l1a_buf),
    .pop(q_pop), .dout(q_buf), .level(q_level)
  );

  always_ff @(posedge clk) begin
    if (rst)                ovf_err <= 1'b0;
    else if (l1a && q_full) ovf_err <= 1'b1;
  end

  tpx_patmem #(.DW(DW), .DEPTH(PAT_DEPTH)) u_patmem (
    .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  tpx_seq #(
    .AW(AW), .DESC_N(DESC_N), .GAP_W(GAP_W), .DLY_W(DLY_W),
    .BUF_W(BUF_W), .OUT_DEPTH(OUT_DEPTH)
  ) u_seq (
    .clk(clk), .rst(rst),
    .desc_we(desc_we), .desc_idx(desc_idx), .desc_start(desc_start),
    .desc_words(desc_words), .desc_gap(desc_gap), .desc_delay(desc_delay),
    .step_mode(step_mode), .last_entry(last_entry),
    .q_empty(q_empty), .q_buf(q_buf), .q_pop(q_pop),
    .out_level(o_level), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .pend_v(pend_v), .pend_eoe(pend_eoe), .pend_zero(pend_zero), .pend_buf(pend_buf)
  );

  assign o_din = {pend_buf, pend_eoe, pend_zero ? '0 : mem_rdata};

  tpx_fifo #(.W(OW), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk(clk), .rst(rst), .push(pend_v), .din(o_din),
    .pop(tx_ready), .dout(o_dout), .level(o_level)
  );

  assign tx_valid = (o_level != '0);
  assign tx_data  = o_dout[DW-1:0];
  assign tx_eoe   = o_dout[DW];
  assign tx_buf   = o_dout[OW-1:DW+1];

  // R9
  out_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    pend_v |-> (o_level != OLW'(OUT_DEPTH)));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eoe) && $stable(tx_buf)));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  // R2
  no_spurious_push_chk: assert property (@(posedge clk) disable iff (rst)
    (q_empty && !pend_v && o_level == '0 && u_seq.state == tpx_pkg::ST_IDLE) |=> !tx_valid);
endmodule

// File: tb/tpx_top_tb.sv
module tpx_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int PAT_DEPTH = 1024;
  localparam int AW = 10;

  logic clk = 0, rst = 1;
  logic pat_we = 0; logic [AW-1:0] pat_addr = '0; logic [DW-1:0] pat_wdata = '0;
  logic desc_we = 0; logic [2:0] desc_idx = '0; logic [AW-1:0] desc_start = '0;
  logic [AW:0] desc_words = '0; logic [7:0] desc_gap = '0; logic [24:0] desc_delay = '0;
  logic step_mode = 0; logic [2:0] last_entry = '0;
  logic l1a = 0; logic [1:0] l1a_buf = '0;
  logic tx_valid, tx_ready = 1, tx_eoe, ovf_err;
  logic [DW-1:0] tx_data; logic [1:0] tx_buf;

  tpx_top u_dut (
    .clk(clk), .rst(rst), .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
    .desc_we(desc_we), .desc_idx(desc_idx), .desc_start(desc_start), .desc_words(desc_words),
    .desc_gap(desc_gap), .desc_delay(desc_delay), .step_mode(step_mode), .last_entry(last_entry),
    .l1a(l1a), .l1a_buf(l1a_buf), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_eoe(tx_eoe), .tx_buf(tx_buf), .ovf_err(ovf_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, nb = 0, t_l1a = 0;
  logic [DW-1:0] b_data [256]; logic b_eoe [256]; logic [1:0] b_buf [256]; int b_cyc [256];

  always @(posedge clk) cyc++;
  always @(negedge clk) if (!rst && tx_valid && tx_ready && nb < 256) begin
    b_data[nb] = tx_data; b_eoe[nb] = tx_eoe; b_buf[nb] = tx_buf; b_cyc[nb] = cyc; nb++;
  end

  function automatic logic [DW-1:0] pat(int a);
    return 32'h5A00_0000 + 32'(a) * 7;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic tick(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1; tx_ready = 1; step_mode = 0; last_entry = '0;
    tick(2); rst = 0; nb = 0;
  endtask

  task automatic set_desc(int idx, int start, int words, int gap, int dly);
    desc_we = 1; desc_idx = 3'(idx); desc_start = AW'(start); desc_words = (AW+1)'(words);
    desc_gap = 8'(gap); desc_delay = 25'(dly); tick(1); desc_we = 0;
  endtask

  task automatic fire(int b);
    l1a = 1; l1a_buf = 2'(b); tick(1); t_l1a = cyc; l1a = 0;
  endtask

  task automatic wait_beats(int n);
    for (int i = 0; i < 3000 && nb < n; i++) tick(1);
    tick(10);
  endtask

  task automatic load_patterns();
    for (int i = 0; i < PAT_DEPTH; i++) begin
      pat_we = 1; pat_addr = AW'(i); pat_wdata = pat(i); tick(1);
    end
    pat_we = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(tx_valid == 0, "R1 valid after reset", tx_valid, 0);
    chk(ovf_err == 0, "R1 ovf after reset", ovf_err, 0);
  endtask

  task automatic t_idle();
    do_reset(); set_desc(0, 5, 3, 0, 0); tick(40);
    chk(nb == 0, "R2 no words without trigger", nb, 0);
  endtask

  task automatic t_basic();
    do_reset(); set_desc(0, 16, 5, 0, 7); fire(2); wait_beats(5);
    chk(nb == 5, "R3 word count", nb, 5);
    for (int k = 0; k < 5; k++) begin
      chk(b_data[k] == pat(16 + k), "R3 data", b_data[k], pat(16 + k));
      chk(b_eoe[k] == (k == 4), "R3 eoe", b_eoe[k], k == 4);
      chk(b_buf[k] == 2, "R3 buffer number", b_buf[k], 2);
    end
    chk(b_cyc[0] - t_l1a == 11, "R4 start delay", b_cyc[0] - t_l1a, 11);
    do_reset(); set_desc(0, 16, 1, 0, 0); fire(1); wait_beats(1);
    chk(b_cyc[0] - t_l1a == 4, "R4 zero delay", b_cyc[0] - t_l1a, 4);
  endtask

  task automatic t_gap();
    do_reset(); set_desc(0, 100, 4, 3, 0); fire(0); wait_beats(4);
    chk(nb == 4, "R5 word count", nb, 4);
    for (int k = 0; k < 3; k++)
      chk(b_cyc[k+1] - b_cyc[k] == 4, "R5 gap spacing", b_cyc[k+1] - b_cyc[k], 4);
  endtask

  task automatic t_empty();
    do_reset(); set_desc(0, 40, 0, 0, 2); fire(3); wait_beats(1); tick(20);
    chk(nb == 1, "R6 single beat", nb, 1);
    chk(b_eoe[0] == 1, "R6 eoe", b_eoe[0], 1);
    chk(b_data[0] == 0, "R6 zero data", b_data[0], 0);
    chk(b_buf[0] == 3, "R6 buffer number", b_buf[0], 3);
  endtask

  task automatic t_mode();
    do_reset();
    set_desc(0, 200, 2, 0, 0); set_desc(1, 300, 2, 0, 0); set_desc(2, 400, 2, 0, 0);
    fire(0); wait_beats(2); fire(0); wait_beats(4);
    chk(b_data[0] == pat(200), "R7 repeat first", b_data[0], pat(200));
    chk(b_data[2] == pat(200), "R7 repeat second", b_data[2], pat(200));
    do_reset(); step_mode = 1; last_entry = 3'd2;
    for (int e = 0; e < 4; e++) begin fire(1); wait_beats(2 * (e + 1)); end
    for (int e = 0; e < 4; e++)
      chk(b_data[2*e] == pat(200 + 100 * (e % 3)), "R7 step order", b_data[2*e], pat(200 + 100 * (e % 3)));
  endtask

  task automatic t_wrap();
    do_reset(); set_desc(0, PAT_DEPTH - 2, 4, 0, 0); fire(0); wait_beats(4);
    for (int k = 0; k < 4; k++)
      chk(b_data[k] == pat((PAT_DEPTH - 2 + k) % PAT_DEPTH), "R10 address wrap", b_data[k], pat((PAT_DEPTH - 2 + k) % PAT_DEPTH));
  endtask

  task automatic t_queue();
    int bufs [5] = '{1, 2, 3, 0, 1};
    do_reset(); set_desc(0, 500, 2, 0, 60);
    for (int e = 0; e < 5; e++) fire(bufs[e]);
    chk(ovf_err == 0, "R8 no overflow at 4 queued", ovf_err, 0);
    fire(2); tick(1);
    chk(ovf_err == 1, "R8 overflow flagged", ovf_err, 1);
    wait_beats(10); tick(100);
    chk(nb == 10, "R8 five events served", nb, 10);
    for (int e = 0; e < 5; e++)
      chk(b_buf[2*e] == bufs[e], "R8 queue order", b_buf[2*e], bufs[e]);
    chk(ovf_err == 1, "R8 overflow sticky", ovf_err, 1);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] held;
    do_reset(); tx_ready = 0; set_desc(0, 700, 6, 0, 0); fire(1); tick(15);
    chk(tx_valid == 1, "R9 valid while stalled", tx_valid, 1);
    held = tx_data;
    tick(5);
    chk(tx_data == held && held == pat(700), "R9 data held", tx_data, pat(700));
    tx_ready = 1; wait_beats(6);
    chk(nb == 6, "R9 no loss", nb, 6);
    for (int k = 0; k < 6; k++)
      chk(b_data[k] == pat(700 + k), "R9 order after stall", b_data[k], pat(700 + k));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(2); rst = 0;
    load_patterns();
    t_reset(); t_idle(); t_basic(); t_gap(); t_empty();
    t_mode(); t_wrap(); t_queue(); t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule